// File: doc/BRIEF.md
# Time-Multiplexed Spiking Prediction Sequencer

This block is the control path of a spiking prediction network with eight outputs. The eight output models share one arithmetic datapath and two single-port memories. One memory holds the weight coefficients and the other holds the convolution state. The datapath and the memories sit outside the block. The sequencer supplies their addresses, write enables, channel and basis-order indices, and phase strobes.

Operation has two phases.

- **Configuration.** Every word arrives serially on a 32-bit input. The first eight words are noise deviation values, one per model, and are held in registers. Next come the full weight memory image and then the full state memory image, each written in ascending address order. When the last word is accepted, a done flag rises and stays high until reset.
- **Prediction.** The sequencer walks the models 0 to 7 in turn and then starts over, indefinitely. For each model it:
  - reads the constant weight;
  - runs 65 convolution periods of three cycles each: 64 input channels, then the feedback channel;
  - waits for the datapath pipeline to drain;
  - pulses a result strobe, at which it captures the model's output spike. That spike is presented as the model's feedback input in the next round.

Each model occupies 196 words in each memory. The word for channel `c` (0..64, where 64 is feedback) and basis order `o` (0..2) sits at `model*196 + 1 + c*3 + o`. Offset 0 of each model holds the constant weight.

Top module: `nps_seq`

## Requirements
- R1: After reset, load_done, wmem_we, smem_we, const_rd, conv_first, fb_active and result_valid are all 0.
- R2: The first 8 accepted load words assert neither write enable. Word k is stored as model k's deviation. During prediction, dev_word shows the deviation of the model on model_idx.
- R3: Accepted load words 8 to 1575 assert wmem_we only, with mem_addr = word index − 8 (weight addresses 0..1567, ascending).
- R4: Accepted load words 1576 to 3143 assert smem_we only, with mem_addr = word index − 1576 (state addresses 0..1567, ascending).
- R5: A cycle with load_valid low writes nothing and does not advance the load index. load_done rises the cycle after the 3144th word is accepted and stays high until reset. load_valid after that has no effect (both write enables stay 0).
- R6: Each model's turn starts with one cycle in which const_rd = 1 and mem_addr = model × 196.
- R7: Next come 65 periods of 3 cycles. In each cycle chan_idx = c and ord_idx = o, with o stepping 0, 1, 2 inside each period, and mem_addr = model×196 + 1 + 3c + o. conv_first is 1 exactly when o = 0. fb_active is 1 exactly when c = 64.
- R8: After the last period there are DRAIN (default 4) quiet cycles with no strobe. Then result_valid is 1 for one cycle, and spike_in is captured for that model in that cycle.
- R9: Models run in order 0,1,…,7, and model 0 follows model 7, forever; each turn takes 201 cycles at default settings.
- R10: fb_spike shows the spike captured for the current model in the previous round, or 0 before its first capture.
- R11: mem_wdata always equals load_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | A configuration word is present |
| load_data | input | 32 | Configuration word |
| load_done | output | 1 | All configuration words loaded; prediction running |
| wmem_we | output | 1 | Weight memory write enable |
| smem_we | output | 1 | State memory write enable |
| mem_addr | output | 11 | Shared word address for both memories |
| mem_wdata | output | 32 | Memory write data |
| dev_word | output | 32 | Noise deviation of the current model |
| model_idx | output | 3 | Current output model |
| chan_idx | output | 7 | Current source channel (64 = feedback) |
| ord_idx | output | 2 | Current basis order |
| const_rd | output | 1 | Constant-weight read cycle |
| conv_first | output | 1 | First cycle of a convolution period |
| fb_active | output | 1 | Feedback channel period |
| fb_spike | output | 1 | Previous-round spike of the current model |
| result_valid | output | 1 | Model result cycle; spike_in sampled |
| spike_in | input | 1 | Output spike from the threshold datapath |

## Verification
Every output of the block is decoded combinationally from registers. The write enables and the write data also follow load_valid and load_data in the same cycle.

The bench therefore drives each input on the falling edge and checks, one time unit later, the outputs that belong to that same cycle. A word accepted at a rising edge shows its effect on the load index, and on load_done, at the next falling edge.

In prediction the bench counts cycles from the first falling edge after load_done rises. It expects const_rd in that cycle, then 195 convolution cycles, then 4 quiet cycles, then result_valid in cycle 201. A spike driven in the result cycle is expected on fb_spike during the same model's feedback period one round (1608 cycles) later.

// File: rtl/nps_pkg.sv
package nps_pkg;
   typedef enum logic [1:0] {
      ST_CONST  = 2'd0,
      ST_CONV   = 2'd1,
      ST_DRAIN  = 2'd2,
      ST_RESULT = 2'd3
   } walk_st_t;
endpackage

// File: rtl/nps_loader.sv
module nps_loader #(
   parameter int N_MODELS = 8,
   parameter int DEPTH    = 1568,
   parameter int DW       = 32,
   parameter int AW       = 11
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           load_valid,
   input  logic [DW-1:0]                  load_data,
   output logic                           done,
   output logic                           wmem_we,
   output logic                           smem_we,
   output logic [AW-1:0]                  ld_addr,
   output logic [N_MODELS-1:0][DW-1:0]    dev_bank
);
   localparam int TOTAL = N_MODELS + 2 * DEPTH;
   localparam int CNTW  = $clog2(TOTAL + 1);

   logic [CNTW-1:0] cnt;
   logic [CNTW-1:0] off;
   logic            accept, in_dev, in_w;

   assign accept = load_valid && !done;
   assign in_dev = cnt < CNTW'(N_MODELS);
   assign in_w   = !in_dev && (cnt < CNTW'(N_MODELS + DEPTH));
   assign off    = in_w ? cnt - CNTW'(N_MODELS) : cnt - CNTW'(N_MODELS + DEPTH);
   assign ld_addr = off[AW-1:0];
   assign wmem_we = accept && in_w;
   assign smem_we = accept && !in_dev && !in_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (accept) begin
         cnt <= cnt + 1'b1;
         if (cnt == CNTW'(TOTAL - 1)) done <= 1'b1;
      end
   end

   for (genvar g = 0; g < N_MODELS; g++) begin : g_dev
      always_ff @(posedge clk) begin
         if (!rst_n)                             dev_bank[g] <= '0;
         else if (accept && cnt == CNTW'(g))     dev_bank[g] <= load_data;
      end
   end

   // R5: completion is sticky and freezes the memories
   p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);
   p_quiet_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(wmem_we || smem_we));
   // R3/R4: at most one memory written per cycle
   p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wmem_we, smem_we}));
endmodule

// File: rtl/nps_walker.sv
module nps_walker
   import nps_pkg::*;
#(
   parameter int N_MODELS = 8,
   parameter int N_SRC    = 65,
   parameter int N_ORD    = 3,
   parameter int WPM      = 196,
   parameter int DRAIN    = 4,
   parameter int AW       = 11,
   parameter int MW       = 3,
   parameter int CW       = 7,
   parameter int OW       = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   output logic [MW-1:0] model,
   output logic [CW-1:0] chan,
   output logic [OW-1:0] ord,
   output logic [AW-1:0] addr,
   output logic          const_rd,
   output logic          conv_first,
   output logic          fb_active,
   output logic          result_valid
);
   localparam int DRW = (DRAIN > 1) ? $clog2(DRAIN) : 1;

   walk_st_t       st;
   logic [DRW-1:0] dcnt;
   logic           last_ord, last_conv;
   logic [AW-1:0]  base_a, off_a;

   assign last_ord  = ord == OW'(N_ORD - 1);
   assign last_conv = last_ord && chan == CW'(N_SRC - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_CONST;
         model <= '0;
         chan  <= '0;
         ord   <= '0;
         dcnt  <= '0;
      end else if (run) begin
         unique case (st)
            ST_CONST: begin
               st   <= ST_CONV;
               chan <= '0;
               ord  <= '0;
            end
            ST_CONV: begin
               if (last_conv) begin
                  st   <= (DRAIN > 0) ? ST_DRAIN : ST_RESULT;
                  dcnt <= '0;
               end else if (last_ord) begin
                  ord  <= '0;
                  chan <= chan + 1'b1;
               end else begin
                  ord  <= ord + 1'b1;
               end
            end
            ST_DRAIN: begin
               if (dcnt == DRW'(DRAIN - 1)) st <= ST_RESULT;
               else                         dcnt <= dcnt + 1'b1;
            end
            ST_RESULT: begin
               st    <= ST_CONST;
               model <= (model == MW'(N_MODELS - 1)) ? '0 : model + 1'b1;
            end
            default: st <= ST_CONST;
         endcase
      end
   end

   assign base_a = AW'(model) * AW'(WPM);
   assign off_a  = AW'(1) + AW'(chan) * AW'(N_ORD) + AW'(ord);
   assign addr   = (st == ST_CONV) ? base_a + off_a : base_a;

   assign const_rd     = run && st == ST_CONST;
   assign conv_first   = run && st == ST_CONV && ord == '0;
   assign fb_active    = run && st == ST_CONV && chan == CW'(N_SRC - 1);
   assign result_valid = run && st == ST_RESULT;

   p_ord_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ord < OW'(N_ORD));
   p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({const_rd, conv_first, result_valid}));
   p_next_const_r6: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> const_rd);
   p_model_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && model == MW'(N_MODELS - 1)) |=> model == '0);
endmodule

// File: rtl/nps_fbstore.sv
module nps_fbstore #(
   parameter int N_MODELS = 8,
   parameter int MW       = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capture,
   input  logic          spike_in,
   input  logic [MW-1:0] model,
   output logic          fb_spike
);
   logic [N_MODELS-1:0] bank;

   for (genvar g = 0; g < N_MODELS; g++) begin : g_fb
      always_ff @(posedge clk) begin
         if (!rst_n)                              bank[g] <= 1'b0;
         else if (capture && model == MW'(g))     bank[g] <= spike_in;
      end
      p_hold_spike_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (capture && model == MW'(g)) |=> bank[g] == $past(spike_in));
   end

   assign fb_spike = bank[model];
endmodule

// File: rtl/nps_seq.sv
module nps_seq #(
   parameter int N_MODELS = 8,
   parameter int N_CHAN   = 64,
   parameter int N_ORD    = 3,
   parameter int DW       = 32,
   parameter int DRAIN    = 4
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  load_valid,
   input  logic [DW-1:0]                         load_data,
   output logic                                  load_done,
   output logic                                  wmem_we,
   output logic                                  smem_we,
   output logic [$clog2(N_MODELS*(1+(N_CHAN+1)*N_ORD))-1:0] mem_addr,
   output logic [DW-1:0]                         mem_wdata,
   output logic [DW-1:0]                         dev_word,
   output logic [$clog2(N_MODELS)-1:0]           model_idx,
   output logic [$clog2(N_CHAN+1)-1:0]           chan_idx,
   output logic [$clog2(N_ORD)-1:0]              ord_idx,
   output logic                                  const_rd,
   output logic                                  conv_first,
   output logic                                  fb_active,
   output logic                                  fb_spike,
   output logic                                  result_valid,
   input  logic                                  spike_in
);
   localparam int N_SRC = N_CHAN + 1;
   localparam int WPM   = 1 + N_SRC * N_ORD;
   localparam int DEPTH = N_MODELS * WPM;
   localparam int AW    = $clog2(DEPTH);
   localparam int MW    = $clog2(N_MODELS);
   localparam int CW    = $clog2(N_SRC);
   localparam int OW    = $clog2(N_ORD);

   if (N_MODELS < 2 || (1 << MW) != N_MODELS) begin : g_bad_models
      $error("N_MODELS must be a power of two of at least 2");
   end
   if (N_ORD < 2) begin : g_bad_ord
      $error("N_ORD must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   logic [AW-1:0]               ld_addr, walk_addr;
   logic [N_MODELS-1:0][DW-1:0] dev_bank;

   nps_loader #(.N_MODELS(N_MODELS), .DEPTH(DEPTH), .DW(DW), .AW(AW)) u_load (
      .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_data(load_data),
      .done(load_done), .wmem_we(wmem_we), .smem_we(smem_we),
      .ld_addr(ld_addr), .dev_bank(dev_bank));

   nps_walker #(.N_MODELS(N_MODELS), .N_SRC(N_SRC), .N_ORD(N_ORD), .WPM(WPM),
                .DRAIN(DRAIN), .AW(AW), .MW(MW), .CW(CW), .OW(OW)) u_walk (
      .clk(clk), .rst_n(rst_n), .run(load_done), .model(model_idx),
      .chan(chan_idx), .ord(ord_idx), .addr(walk_addr), .const_rd(const_rd),
      .conv_first(conv_first), .fb_active(fb_active), .result_valid(result_valid));

   nps_fbstore #(.N_MODELS(N_MODELS), .MW(MW)) u_fb (
      .clk(clk), .rst_n(rst_n), .capture(result_valid), .spike_in(spike_in),
      .model(model_idx), .fb_spike(fb_spike));

   assign mem_addr  = load_done ? walk_addr : ld_addr;
   assign mem_wdata = load_data;
   assign dev_word  = dev_bank[model_idx];

   // R11: write data is the input word unchanged
   p_wdata_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wmem_we || smem_we) |-> mem_wdata == load_data);
   // R6: prediction starts with a constant read of model 0
   p_first_const_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_done) |-> const_rd && model_idx == '0);
endmodule

// File: tb/nps_seq_tb.sv
module nps_seq_tb;
   localparam int CLK_P = 10;
   localparam int NM = 8, WPM = 196, DEPTH = 1568, NDEV = 8, DRAIN = 4;

   logic        clk = 1'b0, rst_n = 1'b0, load_valid = 1'b0, spike_in = 1'b0;
   logic [31:0] load_data = '0;
   logic        load_done, wmem_we, smem_we, const_rd, conv_first, fb_active, fb_spike, result_valid;
   logic [10:0] mem_addr;
   logic [31:0] mem_wdata, dev_word;
   logic [2:0]  model_idx;
   logic [6:0]  chan_idx;
   logic [1:0]  ord_idx;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;
   logic [NM-1:0] prev_sp = '0;

   always #(CLK_P/2) clk = ~clk;

   nps_seq u_dut (.*);

   function automatic logic [31:0] fword(int k);
      return 32'hA500_0000 ^ (k * 32'h0000_9E37);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 load_done", 32'(load_done), 0);
      chk("R1 write enables", 32'({wmem_we, smem_we}), 0);
      chk("R1 strobes", 32'({const_rd, conv_first, fb_active, result_valid}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 after release", 32'({load_done, const_rd, result_valid}), 0);
   endtask

   task automatic t_load();
      for (int k = 0; k < NDEV + 2 * DEPTH; k++) begin
         if (k == 100 || k == 2000) begin
            @(negedge clk);
            load_valid = 1'b0;
            load_data = 32'hDEAD_BEEF;
            #1;
            chk("R5 idle no write", 32'({wmem_we, smem_we}), 0);
         end
         @(negedge clk);
         load_valid = 1'b1;
         load_data = fword(k);
         #1;
         if (k < NDEV) begin
            chk("R2 deviation word no write", 32'({wmem_we, smem_we}), 0);
         end else if (k < NDEV + DEPTH) begin
            chk("R3 weight write", {mem_addr, wmem_we, smem_we}, {11'(k - NDEV), 2'b10});
         end else begin
            chk("R4 state write", {mem_addr, wmem_we, smem_we}, {11'(k - NDEV - DEPTH), 2'b01});
         end
         if (k % 97 == 0) chk("R11 write data", mem_wdata, fword(k));
         if (k == NDEV + 2 * DEPTH - 1) chk("R5 not done before last", 32'(load_done), 0);
      end
   endtask

   task automatic t_predict(int rounds);
      for (int r = 0; r < rounds; r++) begin
         for (int m = 0; m < NM; m++) begin
            logic sp;
            sp = ((m % 3) == 0) ^ r[0];
            @(negedge clk);
            spike_in = 1'b0;
            load_valid = (r == 0 && m == 0);
            load_data = 32'h1234_5678;
            #1;
            chk("R6 const cycle", {mem_addr, const_rd, 8'(model_idx)}, {11'(m * WPM), 1'b1, 8'(m)});
            chk("R2 deviation shown", dev_word, fword(m));
            chk("R5 done held", 32'(load_done), 1);
            if (r == 0 && m == 0) chk("R5 load ignored after done", 32'({wmem_we, smem_we}), 0);
            for (int c = 0; c < 65; c++) begin
               for (int o = 0; o < 3; o++) begin
                  @(negedge clk);
                  load_valid = 1'b0;
                  #1;
                  chk("R7 conv address", {mem_addr, 7'(chan_idx), 2'(ord_idx)},
                      {11'(m * WPM + 1 + c * 3 + o), 7'(c), 2'(o)});
                  chk("R7 strobes", {conv_first, fb_active, const_rd, result_valid},
                      {(o == 0), (c == 64), 2'b00});
                  if (c == 64) chk("R10 feedback spike", 32'(fb_spike), 32'(prev_sp[m]));
               end
            end
            for (int d = 0; d < DRAIN; d++) begin
               @(negedge clk);
               #1;
               chk("R8 drain quiet", {const_rd, conv_first, result_valid}, 0);
            end
            @(negedge clk);
            spike_in = sp;
            #1;
            chk("R8 result strobe", {result_valid, 8'(model_idx)}, {1'b1, 8'(m)});
            prev_sp[m] = sp;
         end
      end
      @(negedge clk);
      spike_in = 1'b0;
      #1;
      chk("R9 wrap to model 0", {const_rd, 8'(model_idx)}, {1'b1, 8'd0});
   endtask

   initial begin
      t_reset();
      t_load();
      t_predict(3);
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule